// File: doc/BRIEF.md
# Single-Butterfly 64-Point Inverse FFT Engine

This block computes a 64-point complex inverse FFT with one radix-4 butterfly node. The node is reused for all 48 butterfly slots of the transform, which run as three stages of sixteen. A frame arrives one sample per handshake on a valid/ready input and is stored in a 64-entry working array. A stage/index sequencer then steps the butterfly across the array one group of four per cycle. After each stage it permutes the whole array in a single cycle. The finished frame leaves one sample per handshake on a valid/ready output.

Only one frame is in flight at a time. The input stays closed (`in_ready` low) from the last accepted sample until the last output sample is taken. While it is closed, `in_valid` and `in_data` are ignored. The output obeys normal back-pressure: while `out_ready` is low, `out_valid` stays high and `out_data` holds its value. No scaling is applied, so sums wrap at 16 bits.

Top module: `ifft64_superfold`

## Requirements
- R1: Samples are packed as imaginary part in bits 31:16 and real part in bits 15:0, each signed Q1.14. The n-th accepted input sample of a frame loads working entry n (n = 0..63).
- R2: Output sample m of a frame is final entry m, sent in order m = 0..63. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle.
- R3: `in_ready` is low from the 64th input handshake until the 64th output handshake completes, and `in_ready` and `out_valid` are never high together. Input presented while `in_ready` is low has no effect on the results.
- R4: `out_valid` first rises exactly 51 clock cycles after the clock edge of the 64th input handshake. This is 3 stages × (16 butterfly cycles + 1 permute cycle).
- R5: In stage s (0..2), the butterfly at index b (0..15) reads entries 4b+j after twiddle multiply, as a, b, c, d. It writes back y0=a+b+c+d, y1=a+jb−c−jd, y2=a−b+c−d and y3=a−jb−c+jd to the same four entries. Each real or imaginary sum wraps to 16 bits.
- R6: Input j of butterfly b in stage s is multiplied by round(16384·e^{+i·2πk/64}), with k = (b mod 4^s)·4^(2−s)·j, and each table part is rounded to nearest. Each product part is (p + 8192) >> 14 (arithmetic shift), wrapped to 16 bits. Here p is the 32-bit sum xr·tr − xi·ti for the real part, or xr·ti + xi·tr for the imaginary part.
- R7: After the sixteen butterflies of every stage, including the last, the array is replaced by new[i] = old[(i mod 16)·4 + i div 16].
- R8: After reset, `in_ready` is high and `out_valid` is low.
- R9: Frames run back to back with no state carried over. `in_ready` is high on the cycle after the 64th output handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine accepts input samples (load phase) |
| in_data | input | 32 | Input sample {im, re} |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 32 | Output sample {im, re} |

## Verification
The bench sends a unit-like impulse at each of the 64 positions. A wrong twiddle index, a wrong permutation or a mis-steered write-back would therefore move energy to the wrong outputs or rotate it by the wrong phase. Random small-amplitude frames then test rounding of the products. A one-LSB rounding slip or a swapped ±j term in the butterfly shows up as an exact mismatch. During compute, `in_valid` is held high with random data: a design that loaded while busy would corrupt the next result. Random output stalls catch a design that advances or changes `out_data` without a handshake. Counting cycles from the last input handshake catches a sequencer with an extra or missing butterfly or permute cycle.

// File: rtl/ifft64_pkg.sv
package ifft64_pkg;
  localparam int DW      = 16;
  localparam int FRAC    = 14;
  localparam int RADIX   = 4;
  localparam int N_STG   = 3;
  localparam int N_PT    = RADIX ** N_STG;
  localparam int N_GRP   = N_PT / RADIX;
  localparam int PTR_W   = $clog2(N_PT);
  localparam int IDX_W   = $clog2(N_GRP);
  localparam int STG_W   = $clog2(N_STG);
  localparam int LANE_W  = $clog2(RADIX);
  localparam int SAMP_W  = 2 * DW;

  typedef struct packed {
    logic signed [DW-1:0] im;
    logic signed [DW-1:0] re;
  } cplx_t;

  typedef enum logic [1:0] {PH_LOAD, PH_BFLY, PH_PERM, PH_DRAIN} phase_t;

  // cos(2*pi*r/64) in Q1.14 for r = 0..16
  function automatic logic signed [DW-1:0] qcos(input logic [4:0] r);
    case (r)
      5'd0:  qcos = 16'sd16384;
      5'd1:  qcos = 16'sd16305;
      5'd2:  qcos = 16'sd16069;
      5'd3:  qcos = 16'sd15679;
      5'd4:  qcos = 16'sd15137;
      5'd5:  qcos = 16'sd14449;
      5'd6:  qcos = 16'sd13623;
      5'd7:  qcos = 16'sd12665;
      5'd8:  qcos = 16'sd11585;
      5'd9:  qcos = 16'sd10394;
      5'd10: qcos = 16'sd9102;
      5'd11: qcos = 16'sd7723;
      5'd12: qcos = 16'sd6270;
      5'd13: qcos = 16'sd4756;
      5'd14: qcos = 16'sd3196;
      5'd15: qcos = 16'sd1606;
      default: qcos = '0;
    endcase
  endfunction

  // e^{+i*2*pi*k/64}, built from the quarter-wave table by quadrant
  function automatic cplx_t tw_lookup(input logic [PTR_W-1:0] k);
    logic signed [DW-1:0] c, s;
    cplx_t t;
    c = qcos({1'b0, k[3:0]});
    s = qcos(5'd16 - {1'b0, k[3:0]});
    case (k[5:4])
      2'd0: begin t.re = c;  t.im = s;  end
      2'd1: begin t.re = -s; t.im = c;  end
      2'd2: begin t.re = -c; t.im = -s; end
      default: begin t.re = s; t.im = -c; end
    endcase
    return t;
  endfunction

  // stride permutation source index: new[i] = old[perm_src(i)]
  function automatic int perm_src(input int i);
    return (i % N_GRP) * RADIX + i / N_GRP;
  endfunction
endpackage

// File: rtl/ifft64_twiddle.sv
module ifft64_twiddle
  import ifft64_pkg::*;
(
  input  logic [STG_W-1:0] stage,
  input  logic [IDX_W-1:0] idx,
  output cplx_t            tw [RADIX]
);
  logic [PTR_W-1:0] base;

  always_comb begin
    case (stage)
      2'd0:    base = '0;
      2'd1:    base = {idx[1:0], 2'b00};
      default: base = {2'b00, idx};
    endcase
  end

  for (genvar j = 0; j < RADIX; j++) begin : g_tw
    logic [PTR_W-1:0] k;
    assign k     = PTR_W'(base * PTR_W'(j));
    assign tw[j] = tw_lookup(k);
  end
endmodule

// File: rtl/ifft64_bfly4.sv
module ifft64_bfly4
  import ifft64_pkg::*;
(
  input  cplx_t x  [RADIX],
  input  cplx_t tw [RADIX],
  output cplx_t y  [RADIX]
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);

  cplx_t m [RADIX];

  for (genvar j = 0; j < RADIX; j++) begin : g_mul
    logic signed [PW-1:0] xr, xi, tr, ti, pr, pi;
    assign xr = PW'(x[j].re);
    assign xi = PW'(x[j].im);
    assign tr = PW'(tw[j].re);
    assign ti = PW'(tw[j].im);
    assign pr = xr * tr - xi * ti + RND;
    assign pi = xr * ti + xi * tr + RND;
    assign m[j].re = pr[FRAC+DW-1:FRAC];
    assign m[j].im = pi[FRAC+DW-1:FRAC];
  end

  always_comb begin
    y[0].re = m[0].re + m[1].re + m[2].re + m[3].re;
    y[0].im = m[0].im + m[1].im + m[2].im + m[3].im;
    y[1].re = m[0].re - m[1].im - m[2].re + m[3].im;
    y[1].im = m[0].im + m[1].re - m[2].im - m[3].re;
    y[2].re = m[0].re - m[1].re + m[2].re - m[3].re;
    y[2].im = m[0].im - m[1].im + m[2].im - m[3].im;
    y[3].re = m[0].re + m[1].im - m[2].re - m[3].im;
    y[3].im = m[0].im - m[1].re - m[2].im + m[3].re;
  end
endmodule

// File: rtl/ifft64_seq.sv
module ifft64_seq
  import ifft64_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output phase_t           phase,
  output logic [STG_W-1:0] stage,
  output logic [IDX_W-1:0] idx,
  output logic [PTR_W-1:0] cnt
);
  localparam logic [STG_W-1:0] STG_LAST = STG_W'(N_STG - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_GRP - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_PT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      stage <= '0;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == PTR_LAST) begin
            phase <= PH_BFLY;
            stage <= '0;
            idx   <= '0;
          end
        end
        PH_BFLY: begin
          idx <= idx + 1'b1;
          if (idx == IDX_LAST) phase <= PH_PERM;
        end
        PH_PERM: begin
          if (stage == STG_LAST) begin
            phase <= PH_DRAIN;
            stage <= '0;
          end else begin
            phase <= PH_BFLY;
            stage <= stage + 1'b1;
          end
        end
        default: if (out_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == PTR_LAST) phase <= PH_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/ifft64_superfold.sv
module ifft64_superfold
  import ifft64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SAMP_W-1:0] out_data
);
  phase_t           phase;
  logic [STG_W-1:0] stage;
  logic [IDX_W-1:0] idx;
  logic [PTR_W-1:0] cnt;
  logic             load_we, bfly_we, perm_en;

  cplx_t arr [N_PT];
  cplx_t x   [RADIX];
  cplx_t tw  [RADIX];
  cplx_t y   [RADIX];

  ifft64_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .phase     (phase),
    .stage     (stage),
    .idx       (idx),
    .cnt       (cnt)
  );

  ifft64_twiddle u_tw (
    .stage (stage),
    .idx   (idx),
    .tw    (tw)
  );

  ifft64_bfly4 u_bf (
    .x  (x),
    .tw (tw),
    .y  (y)
  );

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_DRAIN);
  assign load_we   = in_ready && in_valid;
  assign bfly_we   = (phase == PH_BFLY);
  assign perm_en   = (phase == PH_PERM);
  assign out_data  = arr[cnt];

  // operand selection: four index-driven muxes over the array
  for (genvar j = 0; j < RADIX; j++) begin : g_opnd
    assign x[j] = arr[{idx, LANE_W'(j)}];
  end

  // working array: load, butterfly write-back or permute per entry
  for (genvar e = 0; e < N_PT; e++) begin : g_ent
    localparam int               SRC  = perm_src(e);
    localparam int               LANE = e % RADIX;
    localparam logic [IDX_W-1:0] GRP  = IDX_W'(e / RADIX);
    localparam logic [PTR_W-1:0] POS  = PTR_W'(e);
    cplx_t q;
    always_ff @(posedge clk) begin
      if (load_we && cnt == POS)      q <= in_data;
      else if (bfly_we && idx == GRP) q <= y[LANE];
      else if (perm_en)               q <= arr[SRC];
    end
    assign arr[e] = q;
  end
endmodule

// File: rtl/ifft64_chk.sv
module ifft64_chk
  import ifft64_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SAMP_W-1:0] out_data
);
  localparam int LAT = N_STG * (N_GRP + 1);

  logic [PTR_W-1:0] n_in, n_out;
  logic             pending;
  logic [7:0]       gap;
  logic             hs_in, hs_out;

  assign hs_in  = in_valid && in_ready;
  assign hs_out = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in <= '0; n_out <= '0; pending <= 1'b0; gap <= '0;
    end else begin
      if (hs_in) n_in <= n_in + 1'b1;
      if (hs_out) n_out <= n_out + 1'b1;
      if (hs_in && n_in == PTR_W'(N_PT - 1)) begin
        pending <= 1'b1;
        gap     <= '0;
      end else if (hs_out && n_out == PTR_W'(N_PT - 1)) begin
        pending <= 1'b0;
      end else if (pending && !out_valid) begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid));

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r3_closed_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !in_ready);

  a_r3_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pending);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (gap == 8'(LAT)));
endmodule

bind ifft64_superfold ifft64_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/ifft64_superfold_tb_top.sv
module ifft64_superfold_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  int src_re [64], src_im [64], exp_re [64], exp_im [64];

  ifft64_superfold dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data)
  );

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0d)", tag, act, expv, cyc);
    end
  endtask

  // reference transform per R5, R6, R7
  task automatic model();
    int ar [64], ai [64], tr [64], ti [64];
    for (int i = 0; i < 64; i++) begin ar[i] = src_re[i]; ai[i] = src_im[i]; end
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 16; b++) begin
        int mr [4], mi [4];
        for (int j = 0; j < 4; j++) begin
          int base, k, cr, ci, xr, xi;
          base = (s == 0) ? 0 : (s == 1) ? (b % 4) * 4 : b;
          k  = base * j;
          cr = rnd(16384.0 * $cos(6.283185307179586 * k / 64.0));
          ci = rnd(16384.0 * $sin(6.283185307179586 * k / 64.0));
          xr = ar[4*b+j]; xi = ai[4*b+j];
          mr[j] = w16((xr * cr - xi * ci + 8192) >>> 14);
          mi[j] = w16((xr * ci + xi * cr + 8192) >>> 14);
        end
        ar[4*b]   = w16(mr[0] + mr[1] + mr[2] + mr[3]);
        ai[4*b]   = w16(mi[0] + mi[1] + mi[2] + mi[3]);
        ar[4*b+1] = w16(mr[0] - mi[1] - mr[2] + mi[3]);
        ai[4*b+1] = w16(mi[0] + mr[1] - mi[2] - mr[3]);
        ar[4*b+2] = w16(mr[0] - mr[1] + mr[2] - mr[3]);
        ai[4*b+2] = w16(mi[0] - mi[1] + mi[2] - mi[3]);
        ar[4*b+3] = w16(mr[0] + mi[1] - mr[2] - mi[3]);
        ai[4*b+3] = w16(mi[0] - mr[1] - mi[2] + mr[3]);
      end
      for (int i = 0; i < 64; i++) begin
        tr[i] = ar[(i % 16) * 4 + i / 16];
        ti[i] = ai[(i % 16) * 4 + i / 16];
      end
      ar = tr; ai = ti;
    end
    for (int i = 0; i < 64; i++) begin exp_re[i] = ar[i]; exp_im[i] = ai[i]; end
  endtask

  task automatic run_frame(input string tag);
    int i, j, t_last;
    bit first, stalled;
    logic [31:0] held;
    model();
    @(negedge clk);
    check(in_ready === 1'b1, "R9 in_ready open at frame start", int'(in_ready), 1);
    i = 0;
    while (i < 64) begin
      if (i > 0) @(negedge clk);
      in_valid = ($urandom % 8) != 0;
      in_data  = {16'(src_im[i]), 16'(src_re[i])};
      #1;
      if (in_valid && in_ready) begin
        i++;
        t_last = cyc;
      end
    end
    j = 0; first = 1'b1; stalled = 1'b0; held = '0;
    while (j < 64) begin
      @(negedge clk);
      in_valid  = 1'b1;                // ignored while busy (R3)
      in_data   = $urandom;
      out_ready = ($urandom % 10) < 7;
      #1;
      if (out_valid) begin
        if (first) begin
          check(cyc - t_last == 52, "R4 latency", cyc - t_last, 52);
          first = 1'b0;
        end
        if (in_ready) check(1'b0, "R3 in_ready with out_valid", 1, 0);
        if (stalled) check(out_data == held, "R2 data held under stall", int'(out_data), int'(held));
        if (out_ready) begin
          check(int'($signed(out_data[15:0])) == exp_re[j], {tag, " re"},
                int'($signed(out_data[15:0])), exp_re[j]);
          check(int'($signed(out_data[31:16])) == exp_im[j], {tag, " im"},
                int'($signed(out_data[31:16])), exp_im[j]);
          j++;
          if (j == 64) in_valid = 1'b0;
        end
        stalled = !out_ready;
        held    = out_data;
      end else begin
        if (stalled) check(1'b0, "R2 valid dropped under stall", 0, 1);
        if (!first) check(1'b0, "R2 gap inside output frame", 0, 1);
        stalled = 1'b0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(in_ready === 1'b1 && out_valid === 1'b0, "R9 reopen after drain",
          int'(in_ready), 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(in_ready === 1'b1, "R8 in_ready under reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R8 out_valid under reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready === 1'b1 && out_valid === 1'b0, "R8 idle after reset", int'(in_ready), 1);

    // impulse at every position: R1 placement, R6 twiddles, R7 permutation
    for (int p = 0; p < 64; p++) begin
      for (int i = 0; i < 64; i++) begin src_re[i] = 0; src_im[i] = 0; end
      src_re[p] = 3000; src_im[p] = -1000;
      run_frame("R1/R6/R7 impulse");
    end
    // constant frame: R5 sums
    for (int i = 0; i < 64; i++) begin src_re[i] = 200; src_im[i] = -150; end
    run_frame("R5 constant");
    // random frames: R5/R6 rounding
    for (int f = 0; f < 16; f++) begin
      for (int i = 0; i < 64; i++) begin
        src_re[i] = int'($urandom % 601) - 300;
        src_im[i] = int'($urandom % 601) - 300;
      end
      run_frame("R5/R6 random");
    end
    // large random frame: R5 wrap at 16 bits
    for (int i = 0; i < 64; i++) begin
      src_re[i] = int'($urandom % 16001) - 8000;
      src_im[i] = int'($urandom % 16001) - 8000;
    end
    run_frame("R5 wrap");
    summary();
    $finish;
  end
endmodule